// File: doc/BRIEF.md
# Vector-Hold Clock Divider

This block paces a self-test pattern source so that every vector it produces stays unchanged on the inputs of the circuit under test while that circuit keeps running on the full-rate system clock. It counts system clock cycles and raises a single-cycle enable at the end of each hold period. The pattern generators advance only on that enable, which acts as a slow test clock. The circuit under test itself stays on the system clock throughout.

The hold period is a power of two, 2^k system cycles, with k chosen by a tap-select input. The chosen length is normally at least the sequential depth of the circuit under test: the largest number of flip-flops on any path from an input to an output. This lets each held vector propagate through the sequential path it activates. A tap change is taken up only when a new hold period starts, so no vector is cut short. A run enable pauses the count without losing the position inside the current hold. The current position is brought out for observation.

Top module: `hold_clock_divider`

## Requirements
- R1: While rst_n is low, and at the first sample after it is released, bist_en is 0 and hold_cnt is 0.
- R2: With run_en held high and tap_sel = k (0 <= k <= CNT_W), bist_en is high for exactly one cycle after every 2^k running cycles. For k = 0 it is high after every running cycle.
- R3: hold_cnt counts the running cycles elapsed in the current hold, from 0 up to 2^k-1. It is 0 in every cycle in which bist_en is high.
- R4: A tap_sel value above CNT_W is treated as CNT_W, which gives a hold of 2^CNT_W cycles.
- R5: While run_en is low, hold_cnt keeps its value, and bist_en is low from the cycle after run_en falls. When run_en returns high, the same hold continues from where it stopped.
- R6: tap_sel is sampled only on a running cycle in which hold_cnt is 0. A change made while hold_cnt is nonzero has no effect until the next hold begins.
- R7: Starting from hold_cnt = 0 with run_en high, bist_en first reads high after the 2^k-th rising clock edge and not before.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Count enable; low freezes the hold |
| tap_sel | input | SEL_W | Hold length exponent k, clamped to CNT_W |
| bist_en | output | 1 | One-cycle test-clock enable at each hold end |
| hold_cnt | output | CNT_W | Running cycles elapsed in the current hold |

## Verification
A corrupted hold position shows up on hold_cnt in the very next sample. It also moves the following bist_en pulse, so pulse counts over a fixed window no longer match floor(N/2^k). A stale or wrongly captured tap register can only be seen at the end of the current hold: the pulse arrives early or late by up to 2^CNT_W cycles, and hold_cnt stops at the wrong value. The directed tests therefore change tap_sel mid-hold and pause mid-hold, then compare both the pulse position and the final count.

// File: rtl/hcd_pkg.sv
package hcd_pkg;

    // Limit a requested tap exponent to the deepest tap available.
    function automatic int clamp_tap(input int req, input int kmax);
        return (req > kmax) ? kmax : req;
    endfunction

endpackage

// File: rtl/hcd_tap_decoder.sv
module hcd_tap_decoder #(
    parameter int CNT_W = 8,
    parameter int SEL_W = $clog2(CNT_W + 1)
) (
    input  logic [SEL_W-1:0] tap_sel_i,
    output logic [SEL_W-1:0] tap_k_o,
    output logic [CNT_W-1:0] mask_o
);
    import hcd_pkg::*;

    logic [SEL_W-1:0] k_w;

    always_comb begin
        k_w = SEL_W'(clamp_tap(int'(tap_sel_i), CNT_W));
    end

    assign tap_k_o = k_w;

    // Bit i of the terminal-count mask is set when the hold spans that bit.
    for (genvar i = 0; i < CNT_W; i++) begin : g_mask
        assign mask_o[i] = (k_w > SEL_W'(i));
    end

endmodule

// File: rtl/hcd_hold_counter.sv
module hcd_hold_counter #(
    parameter int CNT_W = 8,
    parameter int SEL_W = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en_i,
    input  logic [SEL_W-1:0] tap_req_i,
    input  logic [CNT_W-1:0] mask_i,
    output logic [SEL_W-1:0] eff_k_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             pulse_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [SEL_W-1:0] k;
        logic             pulse;
    } hold_state_t;

    hold_state_t st_d, st_q;
    logic [SEL_W-1:0] eff_k_d;
    logic             wrap_d;

    // A new tap is taken up only when the hold position is zero.
    always_comb begin
        st_d    = st_q;
        eff_k_d = (st_q.cnt == '0) ? tap_req_i : st_q.k;
        wrap_d  = run_en_i && (st_q.cnt == mask_i);
        st_d.pulse = wrap_d;
        if (run_en_i) begin
            st_d.k   = eff_k_d;
            st_d.cnt = wrap_d ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign eff_k_o = eff_k_d;
    assign cnt_o   = st_q.cnt;
    assign pulse_o = st_q.pulse;

    // R5: no enable is produced after an idle cycle
    a_r5_idle_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> !pulse_o);

    // R5: the hold position is frozen while idle
    a_r5_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en_i |=> $stable(st_q.cnt));

    // R3: every enable coincides with the start of a fresh hold
    a_r3_pulse_starts_hold: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_o |-> (st_q.cnt == '0));

    // R6: the captured tap never moves inside a hold
    a_r6_tap_held_mid_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0) |=> $stable(st_q.k));

endmodule

// File: rtl/hold_clock_divider.sv
module hold_clock_divider #(
    parameter int CNT_W = 8,
    parameter int SEL_W = $clog2(CNT_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_en,
    input  logic [SEL_W-1:0] tap_sel,
    output logic             bist_en,
    output logic [CNT_W-1:0] hold_cnt
);

    logic [SEL_W-1:0] tap_clamped;
    logic [SEL_W-1:0] eff_k;
    logic [SEL_W-1:0] eff_k_unused;
    logic [CNT_W-1:0] mask_unused;
    logic [CNT_W-1:0] eff_mask;

    // Clamp the requested tap before it reaches the hold register.
    hcd_tap_decoder #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_req_dec (
        .tap_sel_i (tap_sel),
        .tap_k_o   (tap_clamped),
        .mask_o    (mask_unused)
    );

    // Terminal-count mask for the tap in force this cycle.
    hcd_tap_decoder #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_eff_dec (
        .tap_sel_i (eff_k),
        .tap_k_o   (eff_k_unused),
        .mask_o    (eff_mask)
    );

    hcd_hold_counter #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_en_i  (run_en),
        .tap_req_i (tap_clamped),
        .mask_i    (eff_mask),
        .eff_k_o   (eff_k),
        .cnt_o     (hold_cnt),
        .pulse_o   (bist_en)
    );

    // R4: the clamped tap never exceeds the counter width
    always_comb begin
        a_r4_tap_in_range: assert (int'(tap_clamped) <= CNT_W);
    end

endmodule

// File: tb/hold_clock_divider_bench.sv
module hold_clock_divider_bench;
    localparam int CNT_W = 8;
    localparam int SEL_W = $clog2(CNT_W + 1);
    localparam int ROWS  = 7;
    // columns: tap_sel, running cycles, expected pulses, expected hold_cnt
    localparam int TBL [ROWS][4] = '{
        '{0,   5, 5,  0},
        '{1,   7, 3,  1},
        '{2,   9, 2,  1},
        '{3,   7, 0,  7},
        '{3,  20, 2,  4},
        '{8, 300, 1, 44},
        '{12, 256, 1, 0}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic run_en = 1'b0;
    logic [SEL_W-1:0] tap_sel = '0;
    logic bist_en;
    logic [CNT_W-1:0] hold_cnt;

    int checks = 0;
    int errors = 0;
    int pulses;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hold_clock_divider #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_hold_clock_divider (
        .clk      (clk),
        .rst_n    (rst_n),
        .run_en   (run_en),
        .tap_sel  (tap_sel),
        .bist_en  (bist_en),
        .hold_cnt (hold_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset(input int k);
        @(negedge clk);
        rst_n   = 1'b0;
        run_en  = 1'b0;
        tap_sel = SEL_W'(k);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // Advance n clock edges, counting enables seen after each edge.
    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
            if (bist_en) pulses++;
        end
    endtask

    initial begin
        // R1: reset state
        do_reset(3);
        check("R1 bist_en after reset", int'(bist_en), 0);
        check("R1 hold_cnt after reset", int'(hold_cnt), 0);

        // Table of hold lengths: R2 R3 R4 R7
        for (int r = 0; r < ROWS; r++) begin
            do_reset(TBL[r][0]);
            run_en = 1'b1;
            pulses = 0;
            step(TBL[r][1]);
            check($sformatf("R2 R4 R7 pulses row %0d", r), pulses, TBL[r][2]);
            check($sformatf("R3 hold_cnt row %0d", r), int'(hold_cnt), TBL[r][3]);
        end

        // R5: pause mid-hold keeps position and suppresses enables
        do_reset(2);
        run_en = 1'b1;
        pulses = 0;
        step(2);
        run_en = 1'b0;
        step(5);
        check("R5 no pulse while idle", pulses, 0);
        check("R5 hold_cnt frozen", int'(hold_cnt), 2);
        run_en = 1'b1;
        step(2);
        check("R5 resumed hold ends on time", pulses, 1);
        check("R5 hold_cnt after resume", int'(hold_cnt), 0);

        // R5: dropping run right after an enable stops the next one
        do_reset(0);
        run_en = 1'b1;
        step(3);
        run_en = 1'b0;
        step(1);
        check("R5 bist_en low after run drops", int'(bist_en), 0);

        // R6: tap change mid-hold waits for the next hold
        do_reset(3);
        run_en = 1'b1;
        pulses = 0;
        step(3);
        tap_sel = SEL_W'(1);
        step(4);
        check("R6 old hold not shortened", pulses, 0);
        check("R6 hold_cnt mid old hold", int'(hold_cnt), 7);
        step(1);
        check("R6 old hold ends at 8", pulses, 1);
        step(1);
        check("R2 enable lasts one cycle", int'(bist_en), 0);
        pulses = 0;
        step(3);
        check("R6 new tap in force", pulses, 2);
        check("R6 hold_cnt with new tap", int'(hold_cnt), 0);

        // R1: reset in the middle of a hold
        tap_sel = SEL_W'(3);
        step(5);
        rst_n = 1'b0;
        step(1);
        check("R1 hold_cnt cleared by reset", int'(hold_cnt), 0);
        check("R1 bist_en cleared by reset", int'(bist_en), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule